// File: doc/BRIEF.md
# Coprocessor exception response sequencer

This block is the control core of a floating-point coprocessor's host interface. It owns the response register that the host polls. The register holds one 3-bit primitive at a time: null, transfer-busy, take pre-instruction exception, take mid-instruction exception, or operand transfer. The sequencer moves between primitives in response to three kinds of input: a decoded class for each new command, host writes of an exception acknowledge, and simple strobes. The strobes stand in for execution completion, operand transfer completion and background errors.

A static mode input selects non-concurrent or concurrent operation. In non-concurrent mode, an arithmetic command shows transfer-busy until it finishes. An acknowledged exception returns the sequencer to idle. In concurrent mode, arithmetic runs in the background and the response stays null. An acknowledged pre-instruction exception is retained. Every later arithmetic or store command reports it again, until a context save or a null-frame restore clears it. Errors that background work reports are held pending. Such an error surfaces as a pre-instruction exception on the next command. If a store transfer is in flight when the error is pending, it surfaces as a mid-instruction exception at the end of that store.

The states are IDLE, EXEC, XFER, PRE, HOLD and MID. The transitions are:

- IDLE→EXEC: non-concurrent arithmetic command without fault.
- IDLE→XFER: store command.
- IDLE→PRE: faulting arithmetic command, or any arithmetic or store command while a background error is pending.
- EXEC→IDLE: execution done.
- XFER→IDLE: transfer done with no fault.
- XFER→MID: transfer done with a store fault or a pending background error.
- PRE→IDLE: acknowledge in non-concurrent mode.
- PRE→HOLD: acknowledge in concurrent mode.
- HOLD→PRE: arithmetic or store command.
- HOLD→IDLE: save or null-restore command.
- MID→IDLE: acknowledge.

Top module: `cp_exc_seq`

## Requirements
- R1: While rst is high, and in the first cycle after reset, resp reads 000 (null). No exception is pending.
- R2: In non-concurrent mode (conc_mode=0), an arithmetic command (cmd_class 00) without cmd_fault makes resp 001 (transfer-busy) from the next cycle. resp returns to 000 the cycle after exec_done. In concurrent mode, such a command leaves resp at 000.
- R3: An arithmetic command with cmd_fault makes resp 010 (take pre-instruction exception). In non-concurrent mode, exc_ack then returns resp to 000, and the next arithmetic command executes normally.
- R4: In concurrent mode, exc_ack of a pre-instruction exception leaves resp at 010. While the exception is retained, an arithmetic or store command (11) keeps resp at 010.
- R5: In concurrent mode, a context save (01) or null-frame restore (10) command clears a retained pre-instruction exception. resp becomes 000, and the next arithmetic command executes normally.
- R6: A store command makes resp 100 (operand transfer) until xfer_done. After xfer_done, resp is 000, or 011 (take mid-instruction exception) if the store was issued with cmd_fault.
- R7: exc_ack while resp is 011 makes resp 000 the next cycle.
- R8: In concurrent mode, bg_err sets a pending error that leaves resp at 000. The next arithmetic or store command then reports 010. A save or null-restore command issued first discards the pending error.
- R9: In concurrent mode, bg_err during a store transfer makes resp 011 after xfer_done. It also consumes the pending error.
- R10: exc_ack while idle is ignored. bg_err is ignored in non-concurrent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conc_mode | input | 1 | 1 selects concurrent mode |
| cmd_valid | input | 1 | New command strobe |
| cmd_class | input | 2 | 00 arithmetic, 01 context save, 10 null-frame restore, 11 store |
| cmd_fault | input | 1 | The command raises an exception (pre for arithmetic, mid for store) |
| exec_done | input | 1 | Non-concurrent arithmetic finished |
| xfer_done | input | 1 | Store operand transfer finished |
| bg_err | input | 1 | Error from earlier background work |
| exc_ack | input | 1 | Host wrote an exception acknowledge to the control register |
| resp | output | 3 | Current response primitive |

## Verification
The assertions assume the following about the inputs:

- conc_mode changes only while the sequencer is idle with nothing pending.
- exc_ack does not coincide with a command while an exception is shown.
- The completion strobes arrive only in the state that awaits them.

The stimulus switches mode only between idle phases. Each cycle drives at most one event, with one exception: bg_err is raised during a store transfer on purpose.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
    localparam int RESP_W = 3;
    localparam int CLS_W  = 2;
    localparam int N_CLS  = 1 << CLS_W;

    typedef enum logic [RESP_W-1:0] {
        RSP_NULL = 3'd0,
        RSP_BUSY = 3'd1,
        RSP_PRE  = 3'd2,
        RSP_MID  = 3'd3,
        RSP_XFER = 3'd4
    } resp_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_OP    = 2'd0,
        CLS_SAVE  = 2'd1,
        CLS_NREST = 2'd2,
        CLS_STORE = 2'd3
    } cls_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXEC, ST_XFER, ST_PRE, ST_HOLD, ST_MID
    } st_e;

    typedef struct packed {
        logic op;
        logic save;
        logic nrest;
        logic store;
    } cmd_t;
endpackage

// File: rtl/cpx_cls_dec.sv
module cpx_cls_dec
    import cpx_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CLS_W-1:0] cmd_class,
    output cmd_t             cmd
);
    logic [N_CLS-1:0] hit;

    for (genvar i = 0; i < N_CLS; i++) begin : g_hit
        assign hit[i] = cmd_valid && (cmd_class == CLS_W'(i));
    end

    assign cmd.op    = hit[CLS_OP];
    assign cmd.save  = hit[CLS_SAVE];
    assign cmd.nrest = hit[CLS_NREST];
    assign cmd.store = hit[CLS_STORE];
endmodule

// File: rtl/cpx_pend.sv
module cpx_pend (
    input  logic clk,
    input  logic rst,
    input  logic conc_mode,
    input  logic bg_err,
    input  logic take,
    input  logic clr,
    output logic pend_q
);
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (bg_err && conc_mode)
            pend_q <= 1'b1;
        else if (take || clr)
            pend_q <= 1'b0;
    end

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bg_err && conc_mode) |=> pend_q);

    // R10
    pend_nc_chk: assert property (@(posedge clk) disable iff (rst)
        (!conc_mode && !pend_q) |=> !pend_q);
endmodule

// File: rtl/cpx_fsm.sv
module cpx_fsm
    import cpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conc_mode,
    input  cmd_t              cmd,
    input  logic              cmd_valid,
    input  logic              cmd_fault,
    input  logic              exec_done,
    input  logic              xfer_done,
    input  logic              exc_ack,
    input  logic              pend_q,
    output logic              pend_take,
    output logic              pend_clr,
    output logic [RESP_W-1:0] resp
);
    st_e  st, nxt;
    logic sfault_q;
    logic ctx_cmd, run_cmd;

    assign ctx_cmd = cmd.save || cmd.nrest;
    assign run_cmd = cmd.op || cmd.store;

    always_comb begin
        nxt       = st;
        pend_take = 1'b0;
        pend_clr  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (ctx_cmd) begin
                    pend_clr = 1'b1;
                end else if (run_cmd) begin
                    if (conc_mode && pend_q) begin
                        nxt       = ST_PRE;
                        pend_take = 1'b1;
                    end else if (cmd.op) begin
                        if (cmd_fault)      nxt = ST_PRE;
                        else if (conc_mode) nxt = ST_IDLE;
                        else                nxt = ST_EXEC;
                    end else begin
                        nxt = ST_XFER;
                    end
                end
            end
            ST_EXEC: if (exec_done) nxt = ST_IDLE;
            ST_XFER: begin
                if (xfer_done) begin
                    if (sfault_q) begin
                        nxt = ST_MID;
                    end else if (conc_mode && pend_q) begin
                        nxt       = ST_MID;
                        pend_take = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_PRE:  if (exc_ack) nxt = conc_mode ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (ctx_cmd)      nxt = ST_IDLE;
                else if (run_cmd) nxt = ST_PRE;
            end
            ST_MID:  if (exc_ack) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            sfault_q <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && nxt == ST_XFER)
                sfault_q <= cmd_fault;
        end
    end

    always_comb begin
        unique case (st)
            ST_IDLE:         resp = RSP_NULL;
            ST_EXEC:         resp = RSP_BUSY;
            ST_XFER:         resp = RSP_XFER;
            ST_PRE, ST_HOLD: resp = RSP_PRE;
            ST_MID:          resp = RSP_MID;
            default:         resp = RSP_NULL;
        endcase
    end

    // R7
    mid_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (resp == RSP_MID && exc_ack) |=> resp == RSP_NULL);

    // R4
    pre_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (conc_mode && resp == RSP_PRE && exc_ack && !cmd_valid) |=> resp == RSP_PRE);

    // R6
    mid_from_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(resp == RSP_MID) |-> $past(resp == RSP_XFER && xfer_done));

    // R10
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (resp == RSP_NULL && exc_ack && !cmd_valid) |=> resp == RSP_NULL);

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        resp <= RSP_XFER);
endmodule

// File: rtl/cp_exc_seq.sv
module cp_exc_seq
    import cpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conc_mode,
    input  logic              cmd_valid,
    input  logic [CLS_W-1:0]  cmd_class,
    input  logic              cmd_fault,
    input  logic              exec_done,
    input  logic              xfer_done,
    input  logic              bg_err,
    input  logic              exc_ack,
    output logic [RESP_W-1:0] resp
);
    cmd_t cmd;
    logic pend_q, pend_take, pend_clr;

    cpx_cls_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_class (cmd_class),
        .cmd       (cmd)
    );

    cpx_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .conc_mode (conc_mode),
        .bg_err    (bg_err),
        .take      (pend_take),
        .clr       (pend_clr),
        .pend_q    (pend_q)
    );

    cpx_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .conc_mode (conc_mode),
        .cmd       (cmd),
        .cmd_valid (cmd_valid),
        .cmd_fault (cmd_fault),
        .exec_done (exec_done),
        .xfer_done (xfer_done),
        .exc_ack   (exc_ack),
        .pend_q    (pend_q),
        .pend_take (pend_take),
        .pend_clr  (pend_clr),
        .resp      (resp)
    );

    // R8
    take_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        pend_take |-> pend_q);

    // R9
    take_shows_exc_chk: assert property (@(posedge clk) disable iff (rst)
        pend_take |=> (resp == RSP_PRE || resp == RSP_MID));
endmodule

// File: tb/tb_cp_exc_seq.sv
module tb_cp_exc_seq;
    logic       clk = 1'b0;
    logic       rst, conc_mode, cmd_valid, cmd_fault;
    logic       exec_done, xfer_done, bg_err, exc_ack;
    logic [1:0] cmd_class;
    logic [2:0] resp;

    logic [2:0] exp_q[$];
    string      tag_q[$];
    int         n_chk = 0;
    int         n_bad = 0;
    logic       mode_sel = 1'b0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    cp_exc_seq dut (
        .clk(clk), .rst(rst), .conc_mode(conc_mode), .cmd_valid(cmd_valid),
        .cmd_class(cmd_class), .cmd_fault(cmd_fault), .exec_done(exec_done),
        .xfer_done(xfer_done), .bg_err(bg_err), .exc_ack(exc_ack), .resp(resp)
    );

    // driver: one cycle of stimulus, one expected response pushed
    task automatic step(input logic r, input logic v, input logic [1:0] c,
                        input logic f, input logic ed, input logic xd,
                        input logic be, input logic ak,
                        input logic [2:0] e, input string t);
        @(negedge clk);
        rst = r; conc_mode = mode_sel; cmd_valid = v; cmd_class = c;
        cmd_fault = f; exec_done = ed; xfer_done = xd; bg_err = be; exc_ack = ak;
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle(input logic [2:0] e, input string t);
        step(0, 0, 2'd0, 0, 0, 0, 0, 0, e, t);
    endtask

    task automatic cmd(input logic [1:0] c, input logic f, input logic [2:0] e, input string t);
        step(0, 1, c, f, 0, 0, 0, 0, e, t);
    endtask

    // monitor: pops and compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (resp !== e) begin
                    n_bad++;
                    $display("FAIL %s: resp=%0d expected=%0d", t, resp, e);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: resp=%0d expected=done", resp);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; conc_mode = 0; cmd_valid = 0; cmd_class = 0; cmd_fault = 0;
        exec_done = 0; xfer_done = 0; bg_err = 0; exc_ack = 0;
        step(1, 0, 2'd0, 0, 0, 0, 0, 0, 3'd0, "R1 in reset");
        idle(3'd0, "R1 after reset");
        // non-concurrent mode
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd0, "R10 ack while idle");
        step(0, 0, 2'd0, 0, 0, 0, 1, 0, 3'd0, "R10 bg_err non-concurrent");
        cmd(2'd0, 0, 3'd1, "R2 op busy");
        idle(3'd1, "R2 busy held");
        step(0, 0, 2'd0, 0, 1, 0, 0, 0, 3'd0, "R2 exec_done");
        cmd(2'd0, 0, 3'd1, "R10 no pending after nc bg_err");
        step(0, 0, 2'd0, 0, 1, 0, 0, 0, 3'd0, "R10 exec_done");
        cmd(2'd0, 1, 3'd2, "R3 op fault");
        idle(3'd2, "R3 held");
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd0, "R3 ack to null");
        cmd(2'd0, 0, 3'd1, "R3 next op normal");
        step(0, 0, 2'd0, 0, 1, 0, 0, 0, 3'd0, "R3 exec_done");
        cmd(2'd3, 0, 3'd4, "R6 store xfer");
        idle(3'd4, "R6 xfer held");
        step(0, 0, 2'd0, 0, 0, 1, 0, 0, 3'd0, "R6 clean store end");
        cmd(2'd3, 1, 3'd4, "R6 faulting store xfer");
        step(0, 0, 2'd0, 0, 0, 1, 0, 0, 3'd3, "R6 mid at end");
        idle(3'd3, "R6 mid held");
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd0, "R7 ack mid nc");
        // concurrent mode
        mode_sel = 1'b1;
        cmd(2'd0, 0, 3'd0, "R2 concurrent op stays null");
        cmd(2'd0, 1, 3'd2, "R4 op fault");
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd2, "R4 ack keeps pre");
        idle(3'd2, "R4 retained");
        cmd(2'd0, 0, 3'd2, "R4 op re-reports");
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd2, "R4 second ack keeps pre");
        cmd(2'd3, 0, 3'd2, "R4 store re-reports");
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd2, "R4 third ack keeps pre");
        cmd(2'd1, 0, 3'd0, "R5 save clears");
        cmd(2'd3, 0, 3'd4, "R5 store normal after save");
        step(0, 0, 2'd0, 0, 0, 1, 0, 0, 3'd0, "R5 store end");
        cmd(2'd0, 1, 3'd2, "R5 op fault again");
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd2, "R5 ack retained");
        cmd(2'd2, 0, 3'd0, "R5 null restore clears");
        cmd(2'd0, 0, 3'd0, "R5 op normal after restore");
        step(0, 0, 2'd0, 0, 0, 0, 1, 0, 3'd0, "R8 bg_err null");
        idle(3'd0, "R8 pending silent");
        cmd(2'd3, 0, 3'd2, "R8 pending to pre on store");
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd2, "R8 ack retained");
        cmd(2'd1, 0, 3'd0, "R8 save");
        step(0, 0, 2'd0, 0, 0, 0, 1, 0, 3'd0, "R8 bg_err again");
        cmd(2'd1, 0, 3'd0, "R8 save discards pending");
        cmd(2'd0, 0, 3'd0, "R8 op after discard");
        cmd(2'd3, 0, 3'd4, "R9 store xfer");
        step(0, 0, 2'd0, 0, 0, 0, 1, 0, 3'd4, "R9 bg_err during xfer");
        step(0, 0, 2'd0, 0, 0, 1, 0, 0, 3'd3, "R9 mid at end");
        step(0, 0, 2'd0, 0, 0, 0, 0, 1, 3'd0, "R7 ack mid concurrent");
        cmd(2'd0, 0, 3'd0, "R9 pending consumed");
        idle(3'd0, "R10 final idle");
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule